// File: doc/BRIEF.md
# Camp-On Connection Request Sequencer

This block sits on the transmit side of a serial backplane port, between the parallel word source and the serializer that feeds a crossbar switch. Words pass straight through while the port is idle. When a word tagged as a connection request is accepted, the sequencer stops reading the parallel side. It then keeps re-sending that request to the switch until the switch acknowledges, with a programmable run of idle words after each copy. A shorter gap means the switch sees the request more often, which gives it a higher chance of being granted.

After the acknowledge, the sequencer releases the parallel side, either at once or after an extra programmable wait. The header and data words of the packet then stream through. A floor on the latency from request load to release keeps the timing within what the switch needs. A camp-on flag is high for the whole time the parallel side is held off.

Top module: `camp_tx`

## Requirements
- R1: After reset, `rd_en` is high, `camp_on` is low, `out_tag` is idle (2'b00) and `out_word` is zero.
- R2: While `rd_en` is high, each accepted word and its tag appear on `out_word`/`out_tag` one cycle later. Tag values: idle 2'b00, request 2'b01, header 2'b10, data 2'b11.
- R3: When a word tagged request (2'b01) is accepted, the next cycle has `rd_en` low and `camp_on` high, and emits that request word.
- R4: While waiting for the acknowledge, the request word is re-emitted with exactly `gap_sel` idle words (value 0 to 7, idle word zero) between copies.
- R5: Without an acknowledge, `rd_en` stays low indefinitely.
- R6: With `hold_en` low, `rd_en` rises in the cycle after `sw_ack` is sampled high, and that cycle emits an idle word. The header and data words accepted from then on follow on the output.
- R7: With `hold_en` high, the release comes `hold_cnt` cycles later than in R6. A `hold_cnt` of 0 gives the same timing as R6, and `hold_cnt` is ignored while `hold_en` is low.
- R8: `rd_en` never rises fewer than 9 cycles after the cycle in which the request was accepted. An early acknowledge is held until that floor is reached.
- R9: From the cycle after `sw_ack` is sampled high, no further request word is emitted, even when the acknowledge falls inside an idle gap.
- R10: `camp_on` falls in the same cycle that `rd_en` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 32 | Parallel word, taken when `rd_en` is high |
| in_tag | input | 2 | Type tag of `in_word` |
| gap_sel | input | 3 | Idle words inserted after each repeated request |
| hold_en | input | 1 | Enables the extra wait after the acknowledge |
| hold_cnt | input | 4 | Length of the extra wait in cycles |
| sw_ack | input | 1 | Acknowledge from the switch |
| rd_en | output | 1 | Parallel read enable |
| camp_on | output | 1 | High while the request is being camped |
| out_word | output | 32 | Outgoing word |
| out_tag | output | 2 | Type tag of `out_word` |

## Verification
Two events can collide in one cycle: the acknowledge can arrive in the same cycle that the pacer would launch the next request copy, or in the middle of its idle gap. The acknowledge can also arrive before the latency floor is met, so the floor and the acknowledge decide the release together. The stimulus table places the acknowledge at a repeat boundary, inside a gap, before the floor, and together with a hold period. For each cycle the bench computes the expected request or idle from the gap formula, and the release cycle as the larger of acknowledge plus one and nine, plus the hold count.

// File: rtl/camp_pkg.sv
package camp_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        TAG_IDLE = 2'b00,
        TAG_REQ  = 2'b01,
        TAG_HDR  = 2'b10,
        TAG_DATA = 2'b11
    } wtag_e;

    typedef enum logic [1:0] {
        PH_PASS = 2'b00,
        PH_CAMP = 2'b01,
        PH_HOLD = 2'b10
    } phase_e;

    typedef struct packed {
        wtag_e              tag;
        logic [WORD_W-1:0]  data;
    } lane_t;

    function automatic lane_t idle_lane();
        lane_t l;
        l.tag  = TAG_IDLE;
        l.data = '0;
        return l;
    endfunction
endpackage

// File: rtl/gap_pacer.sv
module gap_pacer #(
    parameter int GAP_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [GAP_W-1:0] gap_sel,
    output logic             fire
);
    logic [GAP_W-1:0] gap_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_left <= '0;
        end else if (load) begin
            gap_left <= gap_sel;
        end else if (step) begin
            if (gap_left == '0) gap_left <= gap_sel;
            else                gap_left <= gap_left - 1'b1;
        end
    end

    assign fire = (gap_left == '0);
endmodule

// File: rtl/lat_floor.sv
module lat_floor #(
    parameter int MIN_LAT = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic ready
);
    localparam int LW = $clog2(MIN_LAT + 1);
    localparam logic [LW-1:0] TOP = LW'(MIN_LAT);
    localparam logic [LW-1:0] THR = LW'(MIN_LAT - 1);

    logic [LW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= TOP;
        else if (load)        cnt <= LW'(1);
        else if (cnt != TOP)  cnt <= cnt + 1'b1;
    end

    assign ready = (cnt >= THR);
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] n_in,
    output logic             last
);
    logic [CNT_W-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst)                rem <= '0;
        else if (load)          rem <= n_in;
        else if (rem != '0)     rem <= rem - 1'b1;
    end

    assign last = (rem == CNT_W'(1));
endmodule

// File: rtl/camp_tx.sv
module camp_tx
    import camp_pkg::*;
#(
    parameter int GAP_W   = 3,
    parameter int HOLD_W  = 4,
    parameter int MIN_LAT = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_word,
    input  logic [1:0]        in_tag,
    input  logic [GAP_W-1:0]  gap_sel,
    input  logic              hold_en,
    input  logic [HOLD_W-1:0] hold_cnt,
    input  logic              sw_ack,
    output logic              rd_en,
    output logic              camp_on,
    output logic [WORD_W-1:0] out_word,
    output logic [1:0]        out_tag
);
    phase_e            phase, phase_n;
    lane_t             out_q, out_n;
    logic [WORD_W-1:0] req_word;
    logic              acked, acked_n;
    logic              loading, fire, floor_ok, hold_last;
    logic              leave, go_hold, step;

    assign loading = (phase == PH_PASS) && (in_tag == TAG_REQ);
    assign acked_n = acked | sw_ack;
    assign step    = (phase == PH_CAMP) && !acked_n;
    assign leave   = (phase == PH_CAMP) && acked_n && floor_ok;
    assign go_hold = hold_en && (hold_cnt != '0);

    gap_pacer #(.GAP_W(GAP_W)) u_pacer (
        .clk(clk), .rst(rst), .load(loading), .step(step),
        .gap_sel(gap_sel), .fire(fire)
    );

    lat_floor #(.MIN_LAT(MIN_LAT)) u_floor (
        .clk(clk), .rst(rst), .load(loading), .ready(floor_ok)
    );

    hold_timer #(.CNT_W(HOLD_W)) u_hold (
        .clk(clk), .rst(rst), .load(leave && go_hold),
        .n_in(hold_cnt), .last(hold_last)
    );

    always_comb begin
        phase_n = phase;
        out_n   = idle_lane();
        unique case (phase)
            PH_PASS: begin
                out_n.tag  = wtag_e'(in_tag);
                out_n.data = in_word;
                if (loading) phase_n = PH_CAMP;
            end
            PH_CAMP: begin
                if (!acked_n && fire) begin
                    out_n.tag  = TAG_REQ;
                    out_n.data = req_word;
                end
                if (leave) phase_n = go_hold ? PH_HOLD : PH_PASS;
            end
            PH_HOLD: begin
                if (hold_last) phase_n = PH_PASS;
            end
            default: phase_n = PH_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_PASS;
            out_q    <= idle_lane();
            req_word <= '0;
            acked    <= 1'b0;
        end else begin
            phase <= phase_n;
            out_q <= out_n;
            if (loading) begin
                req_word <= in_word;
                acked    <= 1'b0;
            end else if (phase == PH_CAMP) begin
                acked <= acked_n;
            end
        end
    end

    assign rd_en    = (phase == PH_PASS);
    assign camp_on  = (phase != PH_PASS);
    assign out_word = out_q.data;
    assign out_tag  = out_q.tag;
endmodule

// File: rtl/camp_tx_chk.sv
module camp_tx_chk #(
    parameter int GAP_W   = 3,
    parameter int MIN_LAT = 9
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       in_tag,
    input logic [GAP_W-1:0] gap_sel,
    input logic             sw_ack,
    input logic             rd_en,
    input logic             camp_on,
    input logic [1:0]       out_tag
);
    logic [7:0] since_load;
    logic [3:0] idle_run;
    logic       ack_seen, prior_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_load <= 8'hFF;
            idle_run   <= '0;
            ack_seen   <= 1'b0;
            prior_req  <= 1'b0;
        end else begin
            if (rd_en && in_tag == 2'b01)  since_load <= 8'd1;
            else if (since_load != 8'hFF)  since_load <= since_load + 8'd1;

            if (rd_en && in_tag == 2'b01)  ack_seen <= 1'b0;
            else if (camp_on && sw_ack)    ack_seen <= 1'b1;

            if (out_tag == 2'b01)                          idle_run <= '0;
            else if (out_tag == 2'b00 && idle_run != 4'hF) idle_run <= idle_run + 4'd1;

            if (!camp_on)                         prior_req <= 1'b0;
            else if (out_tag == 2'b01)            prior_req <= 1'b1;
        end
    end

    AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && in_tag == 2'b01) |=> (!rd_en && camp_on && out_tag == 2'b01)); // R3

    AST_GAP_SPACING: assert property (@(posedge clk) disable iff (rst)
        (camp_on && out_tag == 2'b01 && prior_req) |-> (idle_run == {1'b0, gap_sel})); // R4

    AST_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en) |-> ack_seen); // R5

    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en) |-> (out_tag == 2'b00)); // R6

    AST_LAT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en) |-> (since_load >= 8'(MIN_LAT))); // R8

    AST_NO_REQ_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (camp_on && ack_seen) |-> (out_tag != 2'b01)); // R9
endmodule

bind camp_tx camp_tx_chk #(.GAP_W(GAP_W), .MIN_LAT(MIN_LAT)) u_chk (
    .clk(clk), .rst(rst), .in_tag(in_tag), .gap_sel(gap_sel), .sw_ack(sw_ack),
    .rd_en(rd_en), .camp_on(camp_on), .out_tag(out_tag)
);

// File: tb/tb_camp_tx.sv
`timescale 1ns/1ps
module tb_camp_tx;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] in_word;
    logic [1:0]  in_tag;
    logic [2:0]  gap_sel;
    logic        hold_en;
    logic [3:0]  hold_cnt;
    logic        sw_ack;
    logic        rd_en, camp_on;
    logic [31:0] out_word;
    logic [1:0]  out_tag;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    camp_tx dut (
        .clk(clk), .rst(rst), .in_word(in_word), .in_tag(in_tag),
        .gap_sel(gap_sel), .hold_en(hold_en), .hold_cnt(hold_cnt),
        .sw_ack(sw_ack), .rd_en(rd_en), .camp_on(camp_on),
        .out_word(out_word), .out_tag(out_tag)
    );

    // {gap, hold enable, hold count, ack cycle}
    localparam int NV = 7;
    localparam logic [15:0] VEC [NV] = '{
        {3'd0, 1'b0, 4'd0,  8'd3},   // early ack held by floor (R8)
        {3'd3, 1'b0, 4'd0,  8'd12},  // ack inside idle gap (R9)
        {3'd7, 1'b1, 4'd4,  8'd10},  // hold of 4 (R7)
        {3'd2, 1'b1, 4'd0,  8'd10},  // hold of 0 acts as no hold (R7)
        {3'd5, 1'b0, 4'd9,  8'd20},  // hold count ignored (R7)
        {3'd1, 1'b1, 4'd15, 8'd8},   // ack on floor edge plus long hold
        {3'd4, 1'b0, 4'd0,  8'd45}   // long wait without ack (R5)
    };

    task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual rd/camp/tag/word=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] obs();
        return {rd_en, camp_on, out_tag, out_word};
    endfunction

    task automatic run_vec(int idx);
        int g, hn, ak, rel;
        logic he;
        logic [31:0] w;
        g  = int'(VEC[idx][15:13]);
        he = VEC[idx][12];
        hn = int'(VEC[idx][11:8]);
        ak = int'(VEC[idx][7:0]);
        w  = 32'hC0DE_0000 + 32'(idx);
        rel = ((ak + 1) > 9 ? ak + 1 : 9) + (he ? hn : 0);
        gap_sel = 3'(g); hold_en = he; hold_cnt = 4'(hn);
        in_tag = 2'b00; in_word = '0; sw_ack = 1'b0;
        @(negedge clk);
        chk("R2 ready before load", {rd_en, camp_on, 34'h0}, {1'b1, 1'b0, 34'h0});
        in_tag = 2'b01; in_word = w;
        @(negedge clk);
        for (int k = 1; k <= rel + 2; k++) begin
            logic [35:0] e;
            string lab;
            if (k < rel) begin
                if (k <= ak && ((k - 1) % (g + 1)) == 0) e = {1'b0, 1'b1, 2'b01, w};
                else                                    e = {1'b0, 1'b1, 2'b00, 32'h0};
                lab = (k == 1) ? "R3 load" : (k > ak ? "R9 after ack" : "R4 R5 camping");
            end else if (k == rel) begin
                e = {1'b1, 1'b0, 2'b00, 32'h0};
                lab = he ? "R7 R8 R10 release" : "R6 R8 R10 release";
            end else if (k == rel + 1) begin
                e = {1'b1, 1'b0, 2'b10, 32'hAAAA_0000 + 32'(idx)};
                lab = "R6 header";
            end else begin
                e = {1'b1, 1'b0, 2'b11, 32'h5555_0000 + 32'(idx)};
                lab = "R6 data";
            end
            chk(lab, obs(), e);
            sw_ack = (k == ak);
            if (k == rel)          begin in_tag = 2'b10; in_word = 32'hAAAA_0000 + 32'(idx); end
            else if (k == rel + 1) begin in_tag = 2'b11; in_word = 32'h5555_0000 + 32'(idx); end
            else                   begin in_tag = 2'b00; in_word = '0; end
            @(negedge clk);
        end
        sw_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_word = '0; in_tag = 2'b00; gap_sel = '0;
        hold_en = 1'b0; hold_cnt = '0; sw_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state", obs(), {1'b1, 1'b0, 2'b00, 32'h0});

        for (int i = 0; i < NV; i++) run_vec(i);

        // R2 pass-through of plain words
        in_tag = 2'b11; in_word = 32'h1234_5678;
        @(negedge clk);
        chk("R2 data passes", obs(), {1'b1, 1'b0, 2'b11, 32'h1234_5678});
        in_tag = 2'b10; in_word = 32'h0BAD_F00D;
        @(negedge clk);
        chk("R2 header passes", obs(), {1'b1, 1'b0, 2'b10, 32'h0BAD_F00D});

        // R1 reset in the middle of camping
        in_tag = 2'b01; in_word = 32'h7777_0001; gap_sel = 3'd2;
        @(negedge clk);
        in_tag = 2'b00; in_word = '0;
        chk("R3 camp entered", obs(), {1'b0, 1'b1, 2'b01, 32'h7777_0001});
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid camp", obs(), {1'b1, 1'b0, 2'b00, 32'h0});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule